// File: doc/BRIEF.md
# Ethernet Transmit Error Handler

This block sits beside one Ethernet MAC transmit engine and decides, frame by frame, what went wrong and what to do about it. The transmit engine tells it when a frame begins and ends, when a byte goes out, when its FIFO has run dry, and which retry attempt is in progress. The block also watches the collision and carrier-sense lines from the PHY.

For each error the block raises its own recovery request. A FIFO underrun asks for a deliberately corrupted 32-bit tail and a flush. A late collision or an exhausted retry budget asks for an abort and a flush. A lost carrier is only recorded, and the frame still completes normally. With heartbeat checking enabled, the block waits after the frame for the transceiver's self-test collision and reports when that collision is missing.

The status word is written into the frame's last descriptor by logic outside this block. It arrives with a single-cycle valid pulse. There is no ready signal: the status path cannot apply back-pressure, so the consumer must capture the word in the cycle the pulse is high. All outputs are registered. Each one appears in the cycle after the input event that causes it.

Top module: `eth_tx_err_handler`

## Requirements
- R1: After reset, every output is 0 and the block is idle, waiting for a frame start.
- R2: FIFO underrun is `fifo_empty` high in an active-frame cycle with no `col` and no `frm_end`. In the next cycle it produces a one-cycle pulse on `bad_crc_req` and on `flush_req`, together with `stat_valid`, and sets flag bit 0 (underrun). `abort_req` stays low. The block then returns to idle.
- R3: `crs` low in any active cycle without `col`, while half duplex, sets flag bit 1 (carrier lost). The frame closes normally at `frm_end`: no abort, no flush, no retry.
- R4: While `full_duplex` is 1, `crs` never sets flag bit 1.
- R5: The retry-limit case is a collision before the late point while `attempt_cnt` >= 16. It pulses `abort_req`, `flush_req` and `stat_valid` in the next cycle and sets flag bit 2 (retry limit).
- R6: A collision before the late point with `attempt_cnt` < 16 returns the block to idle silently, with no output pulses, so that a retry can start. A new `frm_start` is then accepted.
- R7: A collision after at least 64 byte strobes of the current frame is a late collision. It pulses `abort_req`, `flush_req` and `stat_valid` and sets flag bit 3, whatever `attempt_cnt` holds. Any collision clears flag bit 1.
- R8: With `hb_check_en` high at `frm_end`, status is held back for a window of 20 cycles. A `col` in any of those cycles closes the frame cleanly. If no `col` arrives, the frame closes with flag bit 4 (heartbeat error), and `hb_irq` pulses together with `stat_valid` when `hb_irq_en` is 1.
- R9: `stat_flags` is cleared in the cycle after an accepted `frm_start`. `stat_valid` is a single-cycle pulse. Without heartbeat checking, a normal frame closes with `stat_valid` in the cycle after `frm_end`.
- R10: `frm_start` is ignored while a frame or a heartbeat window is in progress. It neither clears the flags nor restarts the byte count.
- R11: In an active cycle, `col` takes priority over `frm_end` and `fifo_empty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_start | input | 1 | Frame (or retry attempt) begins |
| frm_end | input | 1 | Last byte of the frame is being sent |
| byte_stb | input | 1 | One byte sent this cycle |
| fifo_empty | input | 1 | Transmit FIFO has no data |
| col | input | 1 | Collision indication from PHY |
| crs | input | 1 | Carrier sense from PHY |
| full_duplex | input | 1 | Full-duplex mode |
| hb_check_en | input | 1 | Enable post-frame heartbeat check |
| hb_irq_en | input | 1 | Unmask heartbeat interrupt |
| attempt_cnt | input | ATT_W (5) | Current attempt number, 1-based |
| abort_req | output | 1 | Stop sending the frame (pulse) |
| bad_crc_req | output | 1 | Append a 32-bit corrupted tail (pulse) |
| flush_req | output | 1 | Flush and close the frame's remaining descriptors (pulse) |
| stat_valid | output | 1 | Status word valid (pulse) |
| stat_flags | output | 5 | {HB, LC, RL, CSL, UN}, bit 0 = UN |
| hb_irq | output | 1 | Heartbeat error interrupt (pulse) |

## Verification
A corrupted frame state shows up at the ports within one cycle of the next line event. A stuck-active state ignores the next `frm_start` and never produces `stat_valid`. A byte count that is wrong by a single byte turns a late collision into a retry-limit report or a silent retry, so the 63/64 byte boundary is driven on both sides. A heartbeat counter that is off by one closes the frame one cycle early or one cycle late, or misreads a 20th-cycle collision. The bench's cycle model catches that in the cycle where the `stat_valid` pulse is expected.

// File: rtl/txerr_pkg.sv
package txerr_pkg;

  localparam int NFLAGS  = 5;
  localparam int FLG_UN  = 0;
  localparam int FLG_CSL = 1;
  localparam int FLG_RL  = 2;
  localparam int FLG_LC  = 3;
  localparam int FLG_HB  = 4;

  typedef enum logic [1:0] {
    TXE_IDLE   = 2'd0,
    TXE_ACTIVE = 2'd1,
    TXE_HBWAIT = 2'd2
  } txe_state_e;

  typedef struct packed {
    logic late_col;
    logic retry_lim;
    logic retry;
    logic done;
    logic underrun;
    logic crs_lost;
    logic any_col;
  } txe_events_t;

endpackage

// File: rtl/txe_byte_timer.sv
module txe_byte_timer #(
  parameter int LATE_BYTES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic byte_stb,
  output logic late
);

  localparam int CW = $clog2(LATE_BYTES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (run && byte_stb && (cnt_q != CW'(LATE_BYTES))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign late = (cnt_q == CW'(LATE_BYTES));

  AST_LATE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (late && !clr) |=> late); // R7

endmodule

// File: rtl/txe_hb_window.sv
module txe_hb_window #(
  parameter int HB_WINDOW = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic col,
  output logic hit,
  output logic miss
);

  localparam int HW = $clog2(HB_WINDOW + 1);

  logic          act_q;
  logic [HW-1:0] cnt_q;

  assign hit  = act_q && col;
  assign miss = act_q && !col && (cnt_q == HW'(HB_WINDOW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (go) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (hit || miss) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (act_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_HB_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (int'(cnt_q) < HB_WINDOW)); // R8

endmodule

// File: rtl/txe_classify.sv
module txe_classify
  import txerr_pkg::*;
#(
  parameter int MAX_ATTEMPTS = 16,
  parameter int ATT_W        = 5
) (
  input  logic             active,
  input  logic             late,
  input  logic             col,
  input  logic             crs,
  input  logic             full_duplex,
  input  logic             frm_end,
  input  logic             fifo_empty,
  input  logic [ATT_W-1:0] attempt_cnt,
  output txe_events_t      ev
);

  logic col_now;
  logic quiet;
  logic at_limit;

  assign col_now  = active && col;
  assign quiet    = active && !col;
  assign at_limit = (int'(attempt_cnt) >= MAX_ATTEMPTS);

  always_comb begin
    ev           = '0;
    ev.any_col   = col_now;
    ev.late_col  = col_now && late;
    ev.retry_lim = col_now && !late && at_limit;
    ev.retry     = col_now && !late && !at_limit;
    ev.done      = quiet && frm_end;
    ev.underrun  = quiet && !frm_end && fifo_empty;
    ev.crs_lost  = quiet && !crs && !full_duplex;
  end

endmodule

// File: rtl/eth_tx_err_handler.sv
module eth_tx_err_handler
  import txerr_pkg::*;
#(
  parameter int LATE_BYTES   = 64,
  parameter int MAX_ATTEMPTS = 16,
  parameter int HB_WINDOW    = 20,
  parameter int ATT_W        = $clog2(MAX_ATTEMPTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_start,
  input  logic              frm_end,
  input  logic              byte_stb,
  input  logic              fifo_empty,
  input  logic              col,
  input  logic              crs,
  input  logic              full_duplex,
  input  logic              hb_check_en,
  input  logic              hb_irq_en,
  input  logic [ATT_W-1:0]  attempt_cnt,
  output logic              abort_req,
  output logic              bad_crc_req,
  output logic              flush_req,
  output logic              stat_valid,
  output logic [NFLAGS-1:0] stat_flags,
  output logic              hb_irq
);

  txe_state_e        st_q, st_d;
  logic [NFLAGS-1:0] flags_q, flags_d;
  logic              abort_d, crc_d, flush_d, valid_d, irq_d;
  logic              accept, active, late;
  logic              hb_go, hb_hit, hb_miss;
  txe_events_t       ev;

  assign accept = (st_q == TXE_IDLE) && frm_start;
  assign active = (st_q == TXE_ACTIVE);
  assign hb_go  = ev.done && hb_check_en;

  txe_byte_timer #(.LATE_BYTES(LATE_BYTES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .run      (active),
    .byte_stb (byte_stb),
    .late     (late)
  );

  txe_classify #(.MAX_ATTEMPTS(MAX_ATTEMPTS), .ATT_W(ATT_W)) u_class (
    .active      (active),
    .late        (late),
    .col         (col),
    .crs         (crs),
    .full_duplex (full_duplex),
    .frm_end     (frm_end),
    .fifo_empty  (fifo_empty),
    .attempt_cnt (attempt_cnt),
    .ev          (ev)
  );

  txe_hb_window #(.HB_WINDOW(HB_WINDOW)) u_hb (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (hb_go),
    .col   (col),
    .hit   (hb_hit),
    .miss  (hb_miss)
  );

  always_comb begin
    st_d    = st_q;
    flags_d = flags_q;
    abort_d = 1'b0;
    crc_d   = 1'b0;
    flush_d = 1'b0;
    valid_d = 1'b0;
    irq_d   = 1'b0;
    unique case (st_q)
      TXE_IDLE: begin
        if (frm_start) begin
          flags_d = '0;
          st_d    = TXE_ACTIVE;
        end
      end
      TXE_ACTIVE: begin
        if (ev.crs_lost) flags_d[FLG_CSL] = 1'b1;
        if (ev.any_col)  flags_d[FLG_CSL] = 1'b0;
        if (ev.late_col) begin
          flags_d[FLG_LC] = 1'b1;
          abort_d = 1'b1;
          flush_d = 1'b1;
          valid_d = 1'b1;
          st_d    = TXE_IDLE;
        end else if (ev.retry_lim) begin
          flags_d[FLG_RL] = 1'b1;
          abort_d = 1'b1;
          flush_d = 1'b1;
          valid_d = 1'b1;
          st_d    = TXE_IDLE;
        end else if (ev.retry) begin
          st_d    = TXE_IDLE;
        end else if (ev.done) begin
          if (hb_check_en) begin
            st_d    = TXE_HBWAIT;
          end else begin
            valid_d = 1'b1;
            st_d    = TXE_IDLE;
          end
        end else if (ev.underrun) begin
          flags_d[FLG_UN] = 1'b1;
          crc_d   = 1'b1;
          flush_d = 1'b1;
          valid_d = 1'b1;
          st_d    = TXE_IDLE;
        end
      end
      TXE_HBWAIT: begin
        if (hb_hit) begin
          valid_d = 1'b1;
          st_d    = TXE_IDLE;
        end else if (hb_miss) begin
          flags_d[FLG_HB] = 1'b1;
          irq_d   = hb_irq_en;
          valid_d = 1'b1;
          st_d    = TXE_IDLE;
        end
      end
      default: st_d = TXE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= TXE_IDLE;
      flags_q     <= '0;
      abort_req   <= 1'b0;
      bad_crc_req <= 1'b0;
      flush_req   <= 1'b0;
      stat_valid  <= 1'b0;
      hb_irq      <= 1'b0;
    end else begin
      st_q        <= st_d;
      flags_q     <= flags_d;
      abort_req   <= abort_d;
      bad_crc_req <= crc_d;
      flush_req   <= flush_d;
      stat_valid  <= valid_d;
      hb_irq      <= irq_d;
    end
  end

  assign stat_flags = flags_q;

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> !stat_valid); // R9
  AST_FLUSH_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> stat_valid); // R2
  AST_ABORT_NO_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> !bad_crc_req); // R5
  AST_COL_NO_CSL: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && (stat_flags[FLG_LC] || stat_flags[FLG_RL])) |-> !stat_flags[FLG_CSL]); // R7
  AST_HB_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    hb_irq |-> (stat_valid && stat_flags[FLG_HB])); // R8
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (stat_flags == '0)); // R9

endmodule

// File: tb/eth_tx_err_handler_test.sv
`timescale 1ns/1ps
module eth_tx_err_handler_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_start = 0, frm_end = 0, byte_stb = 0, fifo_empty = 0, col = 0, crs = 1;
  logic full_duplex = 0, hb_check_en = 0, hb_irq_en = 0;
  logic [4:0] attempt_cnt = 5'd1;
  logic abort_req, bad_crc_req, flush_req, stat_valid, hb_irq;
  logic [4:0] stat_flags;

  int nchk = 0, nfail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  eth_tx_err_handler uut (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_end(frm_end),
    .byte_stb(byte_stb), .fifo_empty(fifo_empty), .col(col), .crs(crs),
    .full_duplex(full_duplex), .hb_check_en(hb_check_en), .hb_irq_en(hb_irq_en),
    .attempt_cnt(attempt_cnt), .abort_req(abort_req), .bad_crc_req(bad_crc_req),
    .flush_req(flush_req), .stat_valid(stat_valid), .stat_flags(stat_flags),
    .hb_irq(hb_irq)
  );

  task automatic chk(input string rq, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", rq, cyc, got, exp);
    end
  endtask

  // Behavioural reference: 0 idle, 1 sending, 2 waiting for heartbeat
  int ms = 0, mbytes = 0, mhb = 0;
  bit [4:0] mflags;
  bit mv, mab, mbc, mfl, mirq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; mbytes = 0; mhb = 0; mflags = 0;
      mv = 0; mab = 0; mbc = 0; mfl = 0; mirq = 0;
    end else begin
      mv = 0; mab = 0; mbc = 0; mfl = 0; mirq = 0;
      if (ms == 0) begin
        if (frm_start) begin mflags = 0; mbytes = 0; ms = 1; end
      end else if (ms == 1) begin
        int old_bytes;
        old_bytes = mbytes;
        if (byte_stb) mbytes = mbytes + 1;
        if (col) begin
          mflags[1] = 0;
          if (old_bytes >= 64) begin mflags[3] = 1; mab = 1; mfl = 1; mv = 1; ms = 0; end
          else if (attempt_cnt >= 16) begin mflags[2] = 1; mab = 1; mfl = 1; mv = 1; ms = 0; end
          else ms = 0;
        end else begin
          if (!crs && !full_duplex) mflags[1] = 1;
          if (frm_end) begin
            if (hb_check_en) begin ms = 2; mhb = 0; end
            else begin mv = 1; ms = 0; end
          end else if (fifo_empty) begin
            mflags[0] = 1; mbc = 1; mfl = 1; mv = 1; ms = 0;
          end
        end
      end else begin
        if (col) begin mv = 1; ms = 0; end
        else if (mhb == 19) begin mflags[4] = 1; mirq = hb_irq_en; mv = 1; ms = 0; end
        else mhb = mhb + 1;
      end
    end
  end

  // Per-cycle comparison and status capture, away from the active edge
  bit [4:0] last_flags;
  int nvalid = 0, nabort = 0, ncrc = 0, nflush = 0, nirq = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      chk("R2 bad_crc_req", bad_crc_req, mbc);
      chk("R5/R7 abort_req", abort_req, mab);
      chk("R2/R5/R7 flush_req", flush_req, mfl);
      chk("R9 stat_valid", stat_valid, mv);
      chk("R9 stat_flags", stat_flags, mflags);
      chk("R8 hb_irq", hb_irq, mirq);
      if (stat_valid) begin last_flags = stat_flags; nvalid++; end
      if (abort_req) nabort++;
      if (bad_crc_req) ncrc++;
      if (flush_req) nflush++;
      if (hb_irq) nirq++;
    end
  end

  task automatic clear_counts();
    nvalid = 0; nabort = 0; ncrc = 0; nflush = 0; nirq = 0; last_flags = 0;
  endtask

  // Drive one cycle of inputs, starting at a falling edge
  task automatic step(input bit s, input bit e, input bit b, input bit f,
                      input bit c, input bit r);
    frm_start = s; frm_end = e; byte_stb = b; fifo_empty = f; col = c; crs = r;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 1);
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 1, 0, 0, 1);
  endtask

  task automatic check_result(input string rq, input int ev, input int flg,
                              input int ab, input int bc, input int fl);
    idle(25);
    chk({rq, " valid count"}, nvalid, ev);
    chk({rq, " flags"}, last_flags, flg);
    chk({rq, " abort count"}, nabort, ab);
    chk({rq, " crc count"}, ncrc, bc);
    chk({rq, " flush count"}, nflush, fl);
    clear_counts();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 abort", abort_req, 0);
    chk("R1 crc", bad_crc_req, 0);
    chk("R1 flush", flush_req, 0);
    chk("R1 valid", stat_valid, 0);
    chk("R1 flags", stat_flags, 0);
    chk("R1 irq", hb_irq, 0);
    rst_n = 1'b1;
    idle(3);
    clear_counts();

    // R9: normal frame, status the cycle after end
    step(1, 0, 0, 0, 0, 1); send(10); step(0, 1, 1, 0, 0, 1);
    chk("R9 valid after end", stat_valid, 1);
    check_result("R9", 1, 0, 0, 0, 0);

    // R3: carrier drops mid-frame
    step(1, 0, 0, 0, 0, 1); send(5); step(0, 0, 1, 0, 0, 0); send(5); step(0, 1, 1, 0, 0, 1);
    check_result("R3", 1, 5'b00010, 0, 0, 0);

    // R4: full duplex suppresses carrier-lost
    full_duplex = 1;
    step(1, 0, 0, 0, 0, 0); send(5); step(0, 0, 1, 0, 0, 0); step(0, 1, 1, 0, 0, 0);
    check_result("R4", 1, 5'b00000, 0, 0, 0);
    full_duplex = 0;

    // R2: underrun mid-frame
    step(1, 0, 0, 0, 0, 1); send(8); step(0, 0, 0, 1, 0, 1);
    chk("R2 crc pulse", bad_crc_req, 1);
    check_result("R2", 1, 5'b00001, 0, 1, 1);

    // R6: early collision with retries left, then retry completes
    attempt_cnt = 5'd3;
    step(1, 0, 0, 0, 0, 1); send(10); step(0, 0, 1, 0, 1, 1);
    idle(3);
    chk("R6 no status", nvalid, 0);
    step(1, 0, 0, 0, 0, 1); send(4); step(0, 1, 1, 0, 0, 1);
    check_result("R6", 1, 0, 0, 0, 0);

    // R5: collision on 16th attempt before late point (63 bytes)
    attempt_cnt = 5'd16;
    step(1, 0, 0, 0, 0, 1); send(63); step(0, 0, 1, 0, 1, 1);
    check_result("R5", 1, 5'b00100, 1, 0, 1);

    // R7: 64 bytes then collision, late wins even at attempt 16; CSL cleared
    step(1, 0, 0, 0, 0, 1); send(10); step(0, 0, 1, 0, 0, 0); send(53); step(0, 0, 0, 0, 1, 1);
    check_result("R7", 1, 5'b01000, 1, 0, 1);
    attempt_cnt = 5'd1;
    step(1, 0, 0, 0, 0, 1); send(70); step(0, 0, 1, 0, 1, 1);
    check_result("R7 attempt1", 1, 5'b01000, 1, 0, 1);

    // R11: collision with end and empty in same cycle wins
    attempt_cnt = 5'd16;
    step(1, 0, 0, 0, 0, 1); send(5); step(0, 1, 1, 1, 1, 1);
    check_result("R11", 1, 5'b00100, 1, 0, 1);
    attempt_cnt = 5'd2;
    step(1, 0, 0, 0, 0, 1); send(5); step(0, 1, 1, 1, 1, 1);
    check_result("R11 retry", 0, 0, 0, 0, 0);

    // R10: restart mid-frame ignored (byte count kept -> late collision)
    step(1, 0, 0, 0, 0, 1); send(60); step(1, 0, 1, 0, 0, 1); send(3); step(0, 0, 0, 0, 1, 1);
    check_result("R10", 1, 5'b01000, 1, 0, 1);

    // R8: heartbeat in 20th window cycle
    hb_check_en = 1; hb_irq_en = 1; attempt_cnt = 5'd1;
    step(1, 0, 0, 0, 0, 1); send(6); step(0, 1, 1, 0, 0, 1);
    chk("R8 deferred", stat_valid, 0);
    idle(19); step(0, 0, 0, 0, 1, 1);
    chk("R8 hit valid", stat_valid, 1);
    check_result("R8 hit", 1, 0, 0, 0, 0);
    chk("R8 no irq", nirq, 0);

    // R8: heartbeat missing, interrupt unmasked
    step(1, 0, 0, 0, 0, 1); send(6); step(0, 1, 1, 0, 0, 1);
    idle(19);
    chk("R8 not yet", stat_valid, 0);
    step(0, 0, 0, 0, 0, 1);
    chk("R8 miss irq", hb_irq, 1);
    idle(25);
    chk("R8 miss flags", last_flags, 5'b10000);
    chk("R8 irq count", nirq, 1);
    clear_counts();

    // R8: heartbeat missing, interrupt masked; R10 start ignored in window
    hb_irq_en = 0;
    step(1, 0, 0, 0, 0, 1); send(6); step(0, 1, 1, 0, 0, 1);
    idle(5); step(1, 0, 0, 0, 0, 1);
    idle(25);
    chk("R8 masked irq", nirq, 0);
    chk("R10 window flags", last_flags, 5'b10000);
    chk("R10 one status", nvalid, 1);
    clear_counts();
    hb_check_en = 0;

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule